// File: doc/BRIEF.md
# Host Bus Bridge

The bridge connects an asynchronous parallel host processor bus to two internal targets: a register file and one port of a word-wide dual-port RAM. Two further targets, a receive FIFO read port and a transmit FIFO write port, are reached through DMA acknowledge inputs. Strap inputs choose the bus flavour. One flavour has separate active-low read and write strobes. The other has a single data strobe of selectable polarity and a read/write select line. Further straps choose 8-bit or 16-bit data width, the byte order in 8-bit mode, and whether addresses arrive directly on address pins or multiplexed on the data pins through low and high address latches.

Every host strobe passes through a two-flop synchronizer into the core clock. Each strobe start yields one single-cycle request to the selected target. Read data is captured into a hold register and stays on the bus until the strobe is released. When a host RAM access targets the word that the internal engine is using at that moment, the bridge drives an active-low busy output. It holds back the RAM request until the engine has moved on.

Top module: `host_bus_bridge`

## Requirements
- R1: With `strap_style`=0, `host_rd`=0 starts a read and `host_wr`=0 starts a write. Each strobe start issues exactly one single-cycle request.
- R2: With `strap_style`=1, `host_rd` is a data strobe and `host_wr` selects read (1) or write (0). The strobe is active low when `strap_pol`=0 and active high when `strap_pol`=1.
- R3: With `strap_wide`=1, the low byte lane always transfers. The high lane (bits 15:8) transfers only while `host_bhe_n`=0: the write byte-enable bit 1 is set and the read data bits 15:8 carry the word, otherwise they read 0.
- R4: With `strap_wide`=0, data uses `host_din`/`host_dout` bits 7:0 and bits 15:8 read 0. The selected byte of the word is the high byte when (address bit 0 XOR `strap_order`) is 1, otherwise the low byte. A write enables only that byte.
- R5: With `strap_muxed`=1, the address comes from latches and `host_addr` is ignored. The low latch copies `host_din[7:0]` while `host_ale_lo` is 1 and the high latch copies `host_din[15:8]` while `host_ale_hi` is 1. Each latch holds its value while its enable is 0.
- R6: A RAM access needs `mem_sel_n`=2'b00. Otherwise a register access needs `reg_sel_n`=0 and `reg_sel`=1. With neither, no request is issued and the bus is not driven on a read.
- R7: Register word address is address bits 6:1 (byte address = 2 × word). Word 0 reads 0x0010 and a write to it issues no register write. Words at or above `REG_WORDS` read 0 and issue no request.
- R8: Register bits outside `REG_MASK` read as 0 and are cleared in the write data sent to the register file.
- R9: While `rx_ack_n`=0, a read pops the receive FIFO. While `tx_ack_n`=0, a write pushes the transmit FIFO. Both override address bits and all chip selects.
- R10: When a host RAM access targets the word given by `eng_addr` while `eng_act`=1, `busy_n` goes to 0 and the RAM request is withheld until the collision ends. Accesses to other words never raise busy.
- R11: Read data is driven with `host_doe`=1 from capture until the strobe is released. At most one request of any kind is active per cycle.
- R12: After reset no request is active, `host_doe`=0 and `busy_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_style | input | 1 | 0 separate strobes, 1 data strobe with read/write select |
| strap_pol | input | 1 | Data strobe polarity, 0 low, 1 high |
| strap_wide | input | 1 | 0 8-bit bus, 1 16-bit bus |
| strap_order | input | 1 | Byte order in 8-bit mode |
| strap_muxed | input | 1 | 1 takes the address from the latches |
| host_rd | input | 1 | Read strobe or data strobe |
| host_wr | input | 1 | Write strobe or read/write select |
| host_bhe_n | input | 1 | High byte enable, active low |
| host_addr | input | 16 | Direct byte address |
| host_din | input | 16 | Data from host (and address in multiplexed mode) |
| host_dout | output | 16 | Read data to host |
| host_doe | output | 1 | Read data output enable |
| host_ale_lo | input | 1 | Low address latch enable |
| host_ale_hi | input | 1 | High address latch enable |
| mem_sel_n | input | 2 | RAM selects, both active low |
| reg_sel_n | input | 1 | Register select, active low |
| reg_sel | input | 1 | Register select, active high |
| rx_ack_n | input | 1 | Receive DMA acknowledge, active low |
| tx_ack_n | input | 1 | Transmit DMA acknowledge, active low |
| busy_n | output | 1 | RAM word collision, active low |
| ram_req | output | 1 | RAM request pulse |
| ram_we | output | 1 | RAM write when 1 |
| ram_addr | output | RAM_AW | RAM word address |
| ram_be | output | 2 | RAM byte enables |
| ram_wdata | output | 16 | RAM write data |
| ram_rdata | input | 16 | RAM read data, valid the cycle after the request |
| eng_act | input | 1 | Internal engine is using the RAM |
| eng_addr | input | RAM_AW | Word the engine is using |
| reg_rd | output | 1 | Register read pulse |
| reg_wr | output | 1 | Register write pulse |
| reg_addr | output | 6 | Register word address |
| reg_be | output | 2 | Register byte enables |
| reg_wdata | output | 16 | Register write data, unused bits cleared |
| reg_rdata | input | 16 | Register read data, valid the cycle after the request |
| rxf_rd | output | 1 | Receive FIFO pop pulse |
| rxf_rdata | input | 16 | Receive FIFO data, valid the cycle after the pop |
| txf_wr | output | 1 | Transmit FIFO push pulse |
| txf_be | output | 2 | Transmit FIFO byte enables |
| txf_wdata | output | 16 | Transmit FIFO write data |

## Verification
A host RAM access and an engine access to the same word can fall in the same cycle. The bench provokes this by holding `eng_act` on the word the host is writing when the strobe starts. It then checks that `busy_n` is low and that no RAM request has appeared while the strobe is held, and that the write lands with busy cleared once the engine lets go. An engine on a neighbouring word must leave busy high. A DMA acknowledge is also driven together with an active RAM select, and the bench checks that only the FIFO sees the access.

// File: rtl/hbb_pkg.sv
package hbb_pkg;
   localparam int BUS_W  = 16;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      TGT_NONE, TGT_VOID, TGT_VER, TGT_REG, TGT_RAM, TGT_RXF, TGT_TXF
   } tgt_e;

   typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_DATA, ST_HOLD} st_e;

   typedef struct packed {
      tgt_e              tgt;
      logic              wr;
      logic [BUS_W-1:0]  addr;
      logic [BUS_W-1:0]  wdata;
      logic [1:0]        be;
      logic              hi_lane;
      logic              wide;
      logic              bhe_n;
   } acc_t;

   function automatic logic [BUS_W-1:0] fmt_read(input logic wide, input logic hi,
                                                 input logic bhe_n, input logic [BUS_W-1:0] w);
      if (wide)
         return {bhe_n ? {BYTE_W{1'b0}} : w[BUS_W-1:BYTE_W], w[BYTE_W-1:0]};
      else
         return {{BYTE_W{1'b0}}, hi ? w[BUS_W-1:BYTE_W] : w[BYTE_W-1:0]};
   endfunction
endpackage

// File: rtl/hbb_sync.sv
module hbb_sync #(
   parameter int            W       = 1,
   parameter int            STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hbb_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= {STAGES{RST_VAL}};
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/hbb_strobe.sv
module hbb_strobe #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic style,
   input  logic pol,
   input  logic rd_pin,
   input  logic wr_pin,
   output logic rd_act,
   output logic wr_act,
   output logic start
);
   logic rd_s, wr_s, ds_act, acc_q;

   hbb_sync #(.W(2), .STAGES(STAGES), .RST_VAL(2'b11)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({rd_pin, wr_pin}), .q({rd_s, wr_s})
   );

   always_comb begin
      ds_act = pol ? rd_s : !rd_s;
      if (!style) begin
         rd_act = !rd_s;
         wr_act = !wr_s;
      end else begin
         rd_act = ds_act &&  wr_s;
         wr_act = ds_act && !wr_s;
      end
   end

   // acc_q resets to 1 so a strobe level seen during reset never counts as a start
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= 1'b1;
      else        acc_q <= rd_act || wr_act;
   end

   assign start = (rd_act || wr_act) && !acc_q;

   p_one_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !start);
endmodule

// File: rtl/hbb_addr_latch.sv
module hbb_addr_latch #(
   parameter int ADDR_W = 16,
   parameter bit MUX_EN = 1'b1,
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              muxed,
   input  logic              ale_lo,
   input  logic              ale_hi,
   input  logic [ADDR_W-1:0] din,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] addr_eff
);
   localparam int LO_W = ADDR_W / 2;
   localparam int HI_W = ADDR_W - LO_W;

   generate
      if (MUX_EN) begin : g_mux
         logic ale_lo_s, ale_hi_s;
         logic [LO_W-1:0] lat_lo;
         logic [HI_W-1:0] lat_hi;

         hbb_sync #(.W(2), .STAGES(STAGES), .RST_VAL(2'b00)) u_ale_sync (
            .clk(clk), .rst_n(rst_n), .d({ale_hi, ale_lo}), .q({ale_hi_s, ale_lo_s})
         );

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lat_lo <= '0;
               lat_hi <= '0;
            end else begin
               if (ale_lo_s) lat_lo <= din[LO_W-1:0];
               if (ale_hi_s) lat_hi <= din[ADDR_W-1:LO_W];
            end
         end

         assign addr_eff = muxed ? {lat_hi, lat_lo} : addr_in;

         p_lat_lo_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !ale_lo_s |=> $stable(lat_lo));
         p_lat_hi_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !ale_hi_s |=> $stable(lat_hi));
      end else begin : g_direct
         assign addr_eff = addr_in;
      end
   endgenerate
endmodule

// File: rtl/hbb_lane.sv
module hbb_lane
   import hbb_pkg::*;
(
   input  logic             wide,
   input  logic             order,
   input  logic             bhe_n,
   input  logic             a0,
   input  logic [BUS_W-1:0] din,
   output logic             hi_lane,
   output logic [1:0]       be,
   output logic [BUS_W-1:0] wdata
);
   always_comb begin
      if (wide) begin
         hi_lane = 1'b0;
         be      = {!bhe_n, 1'b1};
         wdata   = din;
      end else begin
         hi_lane = a0 ^ order;
         be      = hi_lane ? 2'b10 : 2'b01;
         wdata   = {din[BYTE_W-1:0], din[BYTE_W-1:0]};
      end
   end
endmodule

// File: rtl/host_bus_bridge.sv
module host_bus_bridge
   import hbb_pkg::*;
#(
   parameter int          RAM_WORDS   = 2048,
   parameter int          REG_WORDS   = 43,
   parameter int          SYNC_STAGES = 2,
   parameter bit          MUX_EN      = 1'b1,
   parameter logic [15:0] VERSION     = 16'h0010,
   parameter logic [15:0] REG_MASK    = 16'hFFFF,
   localparam int         RAM_AW      = $clog2(RAM_WORDS),
   localparam int         REG_AW      = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap_style,
   input  logic              strap_pol,
   input  logic              strap_wide,
   input  logic              strap_order,
   input  logic              strap_muxed,
   input  logic              host_rd,
   input  logic              host_wr,
   input  logic              host_bhe_n,
   input  logic [15:0]       host_addr,
   input  logic [15:0]       host_din,
   output logic [15:0]       host_dout,
   output logic              host_doe,
   input  logic              host_ale_lo,
   input  logic              host_ale_hi,
   input  logic [1:0]        mem_sel_n,
   input  logic              reg_sel_n,
   input  logic              reg_sel,
   input  logic              rx_ack_n,
   input  logic              tx_ack_n,
   output logic              busy_n,
   output logic              ram_req,
   output logic              ram_we,
   output logic [RAM_AW-1:0] ram_addr,
   output logic [1:0]        ram_be,
   output logic [15:0]       ram_wdata,
   input  logic [15:0]       ram_rdata,
   input  logic              eng_act,
   input  logic [RAM_AW-1:0] eng_addr,
   output logic              reg_rd,
   output logic              reg_wr,
   output logic [REG_AW-1:0] reg_addr,
   output logic [1:0]        reg_be,
   output logic [15:0]       reg_wdata,
   input  logic [15:0]       reg_rdata,
   output logic              rxf_rd,
   input  logic [15:0]       rxf_rdata,
   output logic              txf_wr,
   output logic [1:0]        txf_be,
   output logic [15:0]       txf_wdata
);
   generate
      if (RAM_AW + 1 > BUS_W) begin : g_bad_ram
         $error("host_bus_bridge: RAM_WORDS does not fit the byte address");
      end
      if (REG_WORDS < 1 || REG_WORDS > (1 << REG_AW)) begin : g_bad_reg
         $error("host_bus_bridge: REG_WORDS out of range");
      end
   endgenerate

   logic             rd_act, wr_act, start, acc_act;
   logic [15:0]      addr_eff;
   logic             hi_lane_n;
   logic [1:0]       be_n;
   logic [15:0]      wdata_n;
   logic [REG_AW-1:0] word_n;
   tgt_e             tgt_n;
   st_e              st;
   acc_t             cap;
   logic [15:0]      rhold;
   logic             busy_q;
   logic             collide, stall, issue;
   logic [15:0]      src_word;

   hbb_strobe #(.STAGES(SYNC_STAGES)) u_strobe (
      .clk(clk), .rst_n(rst_n), .style(strap_style), .pol(strap_pol),
      .rd_pin(host_rd), .wr_pin(host_wr),
      .rd_act(rd_act), .wr_act(wr_act), .start(start)
   );

   hbb_addr_latch #(.ADDR_W(16), .MUX_EN(MUX_EN), .STAGES(SYNC_STAGES)) u_alat (
      .clk(clk), .rst_n(rst_n), .muxed(strap_muxed),
      .ale_lo(host_ale_lo), .ale_hi(host_ale_hi),
      .din(host_din), .addr_in(host_addr), .addr_eff(addr_eff)
   );

   hbb_lane u_lane (
      .wide(strap_wide), .order(strap_order), .bhe_n(host_bhe_n), .a0(addr_eff[0]),
      .din(host_din), .hi_lane(hi_lane_n), .be(be_n), .wdata(wdata_n)
   );

   assign acc_act = rd_act || wr_act;
   assign word_n  = addr_eff[REG_AW:1];

   // target decode: DMA acknowledge first, then RAM, then registers
   always_comb begin
      if (!rx_ack_n && rd_act)                tgt_n = TGT_RXF;
      else if (!tx_ack_n && wr_act)           tgt_n = TGT_TXF;
      else if (mem_sel_n == 2'b00)            tgt_n = TGT_RAM;
      else if (!reg_sel_n && reg_sel) begin
         if (word_n == '0)                    tgt_n = TGT_VER;
         else if (int'(word_n) >= REG_WORDS)  tgt_n = TGT_VOID;
         else                                 tgt_n = TGT_REG;
      end else                                tgt_n = TGT_NONE;
   end

   assign collide = eng_act && (eng_addr == cap.addr[RAM_AW:1]);
   assign stall   = (cap.tgt == TGT_RAM) && collide;
   assign issue   = (st == ST_ISSUE) && acc_act && !stall;

   always_comb begin
      case (cap.tgt)
         TGT_RAM: src_word = ram_rdata;
         TGT_REG: src_word = reg_rdata & REG_MASK;
         TGT_RXF: src_word = rxf_rdata;
         TGT_VER: src_word = VERSION;
         default: src_word = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         cap    <= '0;
         rhold  <= '0;
         busy_q <= 1'b0;
      end else begin
         busy_q <= (st == ST_ISSUE) && acc_act && stall;
         case (st)
            ST_IDLE: if (start) begin
               cap.tgt     <= tgt_n;
               cap.wr      <= wr_act;
               cap.addr    <= addr_eff;
               cap.wdata   <= wdata_n;
               cap.be      <= be_n;
               cap.hi_lane <= hi_lane_n;
               cap.wide    <= strap_wide;
               cap.bhe_n   <= host_bhe_n;
               st          <= (tgt_n == TGT_NONE) ? ST_HOLD : ST_ISSUE;
            end
            ST_ISSUE: begin
               if (!acc_act)   st <= ST_IDLE;
               else if (!stall) st <= ST_DATA;
            end
            ST_DATA: begin
               if (!cap.wr) rhold <= fmt_read(cap.wide, cap.hi_lane, cap.bhe_n, src_word);
               st <= ST_HOLD;
            end
            default: if (!acc_act) st <= ST_IDLE;
         endcase
      end
   end

   assign busy_n    = !busy_q;
   assign host_dout = rhold;
   assign host_doe  = (st == ST_HOLD) && !cap.wr && (cap.tgt != TGT_NONE) && rd_act;

   assign ram_req   = issue && (cap.tgt == TGT_RAM);
   assign ram_we    = cap.wr;
   assign ram_addr  = cap.addr[RAM_AW:1];
   assign ram_be    = cap.be;
   assign ram_wdata = cap.wdata;

   assign reg_rd    = issue && (cap.tgt == TGT_REG) && !cap.wr;
   assign reg_wr    = issue && (cap.tgt == TGT_REG) &&  cap.wr;
   assign reg_addr  = cap.addr[REG_AW:1];
   assign reg_be    = cap.be;
   assign reg_wdata = cap.wdata & REG_MASK;

   assign rxf_rd    = issue && (cap.tgt == TGT_RXF);
   assign txf_wr    = issue && (cap.tgt == TGT_TXF);
   assign txf_be    = cap.be;
   assign txf_wdata = cap.wdata;

   generate
      if (RAM_AW + 1 < BUS_W) begin : g_spare_addr
         logic unused_addr_bits;
         assign unused_addr_bits = ^cap.addr[BUS_W-1:RAM_AW+1];
      end
   endgenerate

   p_req_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ram_req, reg_rd, reg_wr, rxf_rd, txf_wr}));
   p_ram_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ram_req |=> !ram_req);
   p_no_collide_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ram_req |-> !(eng_act && (eng_addr == ram_addr)));
   p_version_ro_r7: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |-> (reg_addr != '0));
   p_reg_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |-> ((reg_wdata & ~REG_MASK) == '0));
   p_doe_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
      host_doe |-> rd_act);
   p_byte_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_req && !cap.wide) |-> ($countones(ram_be) == 1));
endmodule

// File: tb/tb_host_bus_bridge.sv
module tb_host_bus_bridge;
   localparam int RAM_AW = 11;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n = 1'b0;
   logic strap_style = 0, strap_pol = 0, strap_wide = 1, strap_order = 0, strap_muxed = 0;
   logic host_rd = 1, host_wr = 1, host_bhe_n = 0;
   logic [15:0] host_addr = '0, host_din = '0, host_dout;
   logic host_doe, host_ale_lo = 0, host_ale_hi = 0;
   logic [1:0] mem_sel_n = 2'b11;
   logic reg_sel_n = 1, reg_sel = 0, rx_ack_n = 1, tx_ack_n = 1, busy_n;
   logic ram_req, ram_we;
   logic [RAM_AW-1:0] ram_addr;
   logic [1:0] ram_be, reg_be, txf_be;
   logic [15:0] ram_wdata, ram_rdata, reg_wdata, reg_rdata, rxf_rdata, txf_wdata;
   logic eng_act = 0;
   logic [RAM_AW-1:0] eng_addr = '0;
   logic reg_rd, reg_wr, rxf_rd, txf_wr;
   logic [5:0] reg_addr;

   host_bus_bridge #(.REG_MASK(16'h0FFF)) dut (
      .clk(clk), .rst_n(rst_n), .strap_style(strap_style), .strap_pol(strap_pol),
      .strap_wide(strap_wide), .strap_order(strap_order), .strap_muxed(strap_muxed),
      .host_rd(host_rd), .host_wr(host_wr), .host_bhe_n(host_bhe_n),
      .host_addr(host_addr), .host_din(host_din), .host_dout(host_dout), .host_doe(host_doe),
      .host_ale_lo(host_ale_lo), .host_ale_hi(host_ale_hi), .mem_sel_n(mem_sel_n),
      .reg_sel_n(reg_sel_n), .reg_sel(reg_sel), .rx_ack_n(rx_ack_n), .tx_ack_n(tx_ack_n),
      .busy_n(busy_n), .ram_req(ram_req), .ram_we(ram_we), .ram_addr(ram_addr),
      .ram_be(ram_be), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
      .eng_act(eng_act), .eng_addr(eng_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .rxf_rd(rxf_rd), .rxf_rdata(rxf_rdata), .txf_wr(txf_wr), .txf_be(txf_be),
      .txf_wdata(txf_wdata)
   );

   // target models, read data valid the cycle after the request
   logic [15:0] mem [2048];
   logic [15:0] regm [64];
   logic [15:0] tx_last;
   int n_ram = 0, n_regrd = 0, n_regwr = 0, n_rx = 0, n_tx = 0;
   int n_chk = 0, n_fail = 0;

   always @(posedge clk) if (ram_req) begin
      if (ram_we) begin
         if (ram_be[0]) mem[ram_addr][7:0]  <= ram_wdata[7:0];
         if (ram_be[1]) mem[ram_addr][15:8] <= ram_wdata[15:8];
      end else ram_rdata <= mem[ram_addr];
   end
   always @(posedge clk) if (ram_req) n_ram <= n_ram + 1;
   always @(posedge clk) if (reg_wr) begin
      if (reg_be[0]) regm[reg_addr][7:0]  <= reg_wdata[7:0];
      if (reg_be[1]) regm[reg_addr][15:8] <= reg_wdata[15:8];
   end
   always @(posedge clk) if (reg_rd) reg_rdata <= regm[reg_addr] | 16'hF000;
   always @(posedge clk) if (reg_rd) n_regrd <= n_regrd + 1;
   always @(posedge clk) if (reg_wr) n_regwr <= n_regwr + 1;
   always @(posedge clk) if (rxf_rd) begin rxf_rdata <= 16'hC0DE + 16'(n_rx); n_rx <= n_rx + 1; end
   always @(posedge clk) if (txf_wr) begin tx_last <= txf_wdata; n_tx <= n_tx + 1; end

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic apply_cfg(input logic sty, pol, wide, order, muxed);
      @(negedge clk);
      rst_n = 0;
      strap_style = sty; strap_pol = pol; strap_wide = wide;
      strap_order = order; strap_muxed = muxed;
      host_rd = (sty && pol) ? 1'b0 : 1'b1;
      host_wr = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1;
      repeat (4) @(negedge clk);
   endtask

   task automatic sel_ram();  mem_sel_n = 2'b00; reg_sel_n = 1; reg_sel = 0; endtask
   task automatic sel_reg();  mem_sel_n = 2'b11; reg_sel_n = 0; reg_sel = 1; endtask
   task automatic sel_none(); mem_sel_n = 2'b10; reg_sel_n = 1; reg_sel = 0; endtask

   task automatic strobe_on(input logic wr);
      if (!strap_style) begin
         if (wr) host_wr = 0; else host_rd = 0;
      end else begin
         host_wr = !wr;
         host_rd = strap_pol;
      end
   endtask

   task automatic strobe_off();
      host_rd = strap_style ? !strap_pol : 1'b1;
      host_wr = 1'b1;
   endtask

   task automatic access(input logic wr, input logic [15:0] a, input logic [15:0] d,
                         output logic [15:0] rv, output logic oe_held, output logic oe_rel);
      @(negedge clk);
      host_addr = a; host_din = d;
      strobe_on(wr);
      repeat (10) @(negedge clk);
      rv = host_dout; oe_held = host_doe;
      strobe_off();
      repeat (6) @(negedge clk);
      oe_rel = host_doe;
   endtask

   logic [15:0] rv;
   logic oh, orl;
   int b;

   task automatic t_reset();
      apply_cfg(0, 0, 1, 0, 0);
      chk("R12 busy_n", {15'b0, busy_n}, 16'h1);
      chk("R12 doe", {15'b0, host_doe}, 16'h0);
      chk("R12 reqs", {11'b0, ram_req, reg_rd, reg_wr, rxf_rd, txf_wr}, 16'h0);
   endtask

   task automatic t_sep_strobes();
      apply_cfg(0, 0, 1, 0, 0);
      sel_ram(); host_bhe_n = 0;
      b = n_ram;
      access(1, 16'h000A, 16'h1234, rv, oh, orl);
      chk("R1 write data", mem[5], 16'h1234);
      chk("R11 one request per write", 16'(n_ram - b), 16'h1);
      access(0, 16'h000A, 16'h0000, rv, oh, orl);
      chk("R1 read data", rv, 16'h1234);
      chk("R11 doe while held", {15'b0, oh}, 16'h1);
      chk("R11 doe after release", {15'b0, orl}, 16'h0);
   endtask

   task automatic t_width16();
      apply_cfg(0, 0, 1, 0, 0);
      sel_ram(); host_bhe_n = 1;
      access(1, 16'h000A, 16'hABCD, rv, oh, orl);
      chk("R3 upper lane kept", mem[5], 16'h12CD);
      access(0, 16'h000A, 16'h0000, rv, oh, orl);
      chk("R3 upper read zero", rv, 16'h00CD);
      host_bhe_n = 0;
   endtask

   task automatic t_ds_low();
      apply_cfg(1, 0, 1, 0, 0);
      sel_ram();
      access(1, 16'h000C, 16'h5555, rv, oh, orl);
      chk("R2 low strobe write", mem[6], 16'h5555);
      access(0, 16'h000C, 16'h0000, rv, oh, orl);
      chk("R2 low strobe read", rv, 16'h5555);
   endtask

   task automatic t_ds_high();
      apply_cfg(1, 1, 1, 0, 0);
      sel_ram();
      b = n_ram;
      repeat (6) @(negedge clk);
      chk("R2 idle low level no request", 16'(n_ram - b), 16'h0);
      access(1, 16'h000E, 16'h6666, rv, oh, orl);
      chk("R2 high strobe write", mem[7], 16'h6666);
      access(0, 16'h000E, 16'h0000, rv, oh, orl);
      chk("R2 high strobe read", rv, 16'h6666);
   endtask

   task automatic t_byte_order();
      apply_cfg(0, 0, 0, 0, 0);
      sel_ram();
      access(1, 16'h0010, 16'hFF11, rv, oh, orl);
      access(1, 16'h0011, 16'hFF22, rv, oh, orl);
      chk("R4 order0 bytes", mem[8], 16'h2211);
      access(0, 16'h0011, 16'h0000, rv, oh, orl);
      chk("R4 order0 read a0=1", rv, 16'h0022);
      apply_cfg(0, 0, 0, 1, 0);
      sel_ram();
      access(1, 16'h0012, 16'h0033, rv, oh, orl);
      chk("R4 order1 a0=0 high byte", {8'h00, mem[9][15:8]}, 16'h0033);
      access(0, 16'h0012, 16'h0000, rv, oh, orl);
      chk("R4 order1 read", rv, 16'h0033);
   endtask

   task automatic t_muxed();
      apply_cfg(0, 0, 1, 0, 1);
      sel_ram();
      @(negedge clk);
      host_din = 16'h0014; host_ale_lo = 1; host_ale_hi = 1;
      repeat (4) @(negedge clk);
      host_ale_lo = 0; host_ale_hi = 0;
      repeat (4) @(negedge clk);
      access(1, 16'hFFFE, 16'hBEEF, rv, oh, orl);
      chk("R5 latched address write", mem[10], 16'hBEEF);
      access(0, 16'h7FF0, 16'h0000, rv, oh, orl);
      chk("R5 latched address read", rv, 16'hBEEF);
   endtask

   task automatic t_select();
      apply_cfg(0, 0, 1, 0, 0);
      sel_none();
      b = n_ram + n_regwr + n_regrd;
      access(1, 16'h0028, 16'h9999, rv, oh, orl);
      access(0, 16'h0028, 16'h0000, rv, oh, orl);
      chk("R6 no select no request", 16'(n_ram + n_regwr + n_regrd - b), 16'h0);
      chk("R6 no select not driven", {15'b0, oh}, 16'h0);
   endtask

   task automatic t_regs();
      apply_cfg(0, 0, 1, 0, 0);
      sel_reg();
      access(0, 16'h0000, 16'h0000, rv, oh, orl);
      chk("R7 version word", rv, 16'h0010);
      b = n_regwr;
      access(1, 16'h0000, 16'hFFFF, rv, oh, orl);
      chk("R7 version write dropped", 16'(n_regwr - b), 16'h0);
      access(0, 16'h0000, 16'h0000, rv, oh, orl);
      chk("R7 version unchanged", rv, 16'h0010);
      access(1, 16'h0006, 16'hFFFF, rv, oh, orl);
      chk("R8 write mask at word 3", regm[3], 16'h0FFF);
      access(0, 16'h0006, 16'h0000, rv, oh, orl);
      chk("R8 read mask", rv, 16'h0FFF);
      b = n_regrd;
      access(0, 16'h0064, 16'h0000, rv, oh, orl);
      chk("R7 unimplemented word reads zero", rv, 16'h0000);
      chk("R7 unimplemented word no request", 16'(n_regrd - b), 16'h0);
   endtask

   task automatic t_dma();
      apply_cfg(0, 0, 1, 0, 0);
      sel_none(); rx_ack_n = 0;
      access(0, 16'h0030, 16'h0000, rv, oh, orl);
      chk("R9 receive FIFO pop", rv, 16'hC0DE);
      rx_ack_n = 1;
      sel_ram(); tx_ack_n = 0;
      b = n_ram;
      access(1, 16'h0024, 16'h7777, rv, oh, orl);
      chk("R9 transmit FIFO push", tx_last, 16'h7777);
      chk("R9 RAM select overridden", 16'(n_ram - b), 16'h0);
      tx_ack_n = 1;
   endtask

   task automatic t_busy();
      apply_cfg(0, 0, 1, 0, 0);
      sel_ram();
      eng_addr = 11'h013; eng_act = 1;
      access(1, 16'h0024, 16'h4242, rv, oh, orl);
      chk("R10 other word no busy", mem[18], 16'h4242);
      @(negedge clk);
      eng_addr = 11'h012;
      b = n_ram;
      host_addr = 16'h0024; host_din = 16'h5A5A;
      strobe_on(1);
      repeat (10) @(negedge clk);
      chk("R10 busy on collision", {15'b0, busy_n}, 16'h0);
      chk("R10 request withheld", 16'(n_ram - b), 16'h0);
      eng_act = 0;
      repeat (6) @(negedge clk);
      chk("R10 busy cleared", {15'b0, busy_n}, 16'h1);
      chk("R10 deferred write lands", mem[18], 16'h5A5A);
      strobe_off();
      repeat (6) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL all watchdog act=hung exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      t_reset();
      t_sep_strobes();
      t_width16();
      t_ds_low();
      t_ds_high();
      t_byte_order();
      t_muxed();
      t_select();
      t_regs();
      t_dma();
      t_busy();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule